// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a wake-up alarm built on a down-counter. Software writes the number of seconds left into a counter register. It then sets the enables for counting, the interrupt and the wakeup output. A one-cycle strobe on `tick`, arriving once per second, lowers the counter by one. When the counter reaches zero from one, a sticky pending flag is raised. That flag drives the interrupt line and the wakeup line through their own enables.

Software clears the flag by writing a one to it. To reprogram the alarm, software takes these steps in order:

1. Drop all enables and clear the pending flag.
2. Write zero to the counter and wait.
3. Load the new count.
4. Enable again.

A weekly alarm is present only as a stub: an enable bit and an interrupt-enable bit that store and read back, and a pending bit that the block never sets.

The register interface is a simple 32-bit single-cycle write port with combinational read data selected by `addr`.

Top module: `sec_countdown_alarm`

## Requirements
- R1: After reset every register reads 0, and `irq` and `wakeup` are low.
- R2: Offset 0x20 is the seconds counter. A write loads all 32 bits, and a read returns the current value.
- R3: The run enable is bit 0 at offset 0x28. When it is 1, the counter is nonzero and `tick` is high, the counter drops by exactly one on that clock. Without `tick`, or with the run enable at 0, the counter holds.
- R4: A counter at 0 never decrements or wraps, and a tick then never raises the pending flag.
- R5: A tick that takes the counter from 1 to 0 sets the pending flag (bit 0 at offset 0x30). The flag stays set through later ticks until it is cleared.
- R6: Writing 1 to bit 0 at offset 0x30 clears the pending flag. Writing 0 to it leaves the flag unchanged.
- R7: A clear write in the same cycle as an expiring tick leaves the pending flag set.
- R8: `irq` equals pending AND the interrupt enable (bit 0 at offset 0x2C). `wakeup` equals pending AND the wakeup enable (bit 0 at offset 0x50).
- R9: The weekly stub enables (bit 0 at 0x44 and 0x48) store and read back. The weekly pending bit (bit 0 at 0x4C) always reads 0, and writing to it has no visible effect.
- R10: A counter write in the same cycle as a tick loads the written value, and no decrement happens that cycle.
- R11: Enable registers hold only bit 0, and their upper bits read 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| tick | input | 1 | One-cycle strobe per second |
| irq | output | 1 | Interrupt, pending AND interrupt enable |
| wakeup | output | 1 | Wakeup, pending AND wakeup enable |

## Verification
A counter that goes wrong shows up at the next read of offset 0x20. The bench reads the counter after every tick, so a skipped or doubled decrement is caught within one second-strobe. A pending flag that is set early, set late or lost appears on `irq` and `wakeup` one clock after the expiring tick. The sweep over every combination of the two output enables makes a swapped or dropped gate visible at once. Same-cycle collisions of a clear with an expiry, and of a load with a tick, are driven directly. Their outcome is read back on the next clock.

// File: rtl/cda_pkg.sv
package cda_pkg;

  // Register offsets; software and neighbouring logic decode these.
  localparam logic [7:0] OFF_COUNT    = 8'h20;
  localparam logic [7:0] OFF_PEND     = 8'h30;
  localparam logic [7:0] OFF_WEEKPEND = 8'h4C;

  // Single-bit enable registers, in index order:
  // run, interrupt, wakeup, weekly enable, weekly interrupt enable.
  localparam int unsigned NUM_EN  = 5;
  localparam int unsigned EN_RUN  = 0;
  localparam int unsigned EN_IRQ  = 1;
  localparam int unsigned EN_WAKE = 2;
  localparam logic [7:0] EN_OFFS [NUM_EN] = '{8'h28, 8'h2C, 8'h50, 8'h44, 8'h48};

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;
    logic dec;
  } cdaStrobe_t;

endpackage

// File: rtl/cda_counter.sv
module cda_counter
  import cda_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cdaStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             isZero,
  output logic             isOne
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strobe.load) count <= loadVal;
    else if (strobe.dec)  count <= count - ONE;
  end

  assign isZero = (count == '0);
  assign isOne  = (count == ONE);

  // R3: a decrement lowers the count by exactly one
  p_dec_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec && !strobe.load |=> count == $past(count) - ONE);

  // R4: an empty counter stays empty unless loaded
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    isZero && !strobe.load |=> isZero);

  // R10: a load takes the written value
  p_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> count == $past(loadVal));

endmodule

// File: rtl/cda_ctrl.sv
module cda_ctrl
  import cda_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrBit,
  input  logic              tick,
  input  logic [CNT_W-1:0]  count,
  input  logic              isZero,
  input  logic              isOne,
  output cdaStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              wakeup
);

  logic [NUM_EN-1:0] enBits;
  logic pending;
  logic clrHit;
  logic expire;

  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        bitQ <= 1'b0;
      else if (wrEn && addr == ADDR_W'(EN_OFFS[g]))
        bitQ <= wrBit;
    end
    assign enBits[g] = bitQ;
  end

  always_comb begin
    strobe.load = wrEn && (addr == ADDR_W'(OFF_COUNT));
    strobe.dec  = tick && enBits[EN_RUN] && !isZero && !strobe.load;
  end

  assign expire = strobe.dec && isOne;
  assign clrHit = wrEn && (addr == ADDR_W'(OFF_PEND)) && wrBit;

  // Expiry has priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       pending <= 1'b0;
    else if (expire) pending <= 1'b1;
    else if (clrHit) pending <= 1'b0;
  end

  assign irq    = pending && enBits[EN_IRQ];
  assign wakeup = pending && enBits[EN_WAKE];

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(OFF_COUNT)) rdData = DATA_W'(count);
    if (addr == ADDR_W'(OFF_PEND))  rdData = DATA_W'(pending);
    // The weekly pending bit is never set, so OFF_WEEKPEND reads 0.
    for (int i = 0; i < NUM_EN; i++)
      if (addr == ADDR_W'(EN_OFFS[i])) rdData = DATA_W'(enBits[i]);
  end

  // R5: the final tick raises pending
  p_expire_sets_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec && isOne |=> pending);

  // R5: pending stays set until a clear write
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    pending && !clrHit |=> pending);

  // R6: a clear without a competing expiry empties the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    clrHit && !(tick && isOne && enBits[EN_RUN] && !strobe.load) |=> !pending);

  // R4: pending only rises after a tick seen at count one
  p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(tick) && $past(isOne));

endmodule

// File: rtl/sec_countdown_alarm.sv
module sec_countdown_alarm
  import cda_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              tick,
  output logic              irq,
  output logic              wakeup
);

  cdaStrobe_t       strobe;
  logic [CNT_W-1:0] count;
  logic             isZero;
  logic             isOne;

  cda_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrBit  (wrData[0]),
    .tick   (tick),
    .count  (count),
    .isZero (isZero),
    .isOne  (isOne),
    .strobe (strobe),
    .rdData (rdData),
    .irq    (irq),
    .wakeup (wakeup)
  );

  cda_counter #(.CNT_W(CNT_W)) i_counter (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .loadVal (wrData[CNT_W-1:0]),
    .count   (count),
    .isZero  (isZero),
    .isOne   (isOne)
  );

endmodule

// File: tb/test_sec_countdown_alarm.sv
module test_sec_countdown_alarm;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        tick = 1'b0;
  logic        irq;
  logic        wakeup;

  int testCnt = 0;
  int failCnt = 0;

  always #10 clk = ~clk;   // 50 MHz

  sec_countdown_alarm i_sec_countdown_alarm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .tick(tick), .irq(irq), .wakeup(wakeup)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rdCheck(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    foreach (i_offs[k]) rdCheck("R1", i_offs[k], 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 wakeup", {31'b0, wakeup}, 32'h0);

    // R2 full-width counter load
    wr(8'h20, 32'hA5A5_1234);
    rdCheck("R2", 8'h20, 32'hA5A5_1234);

    // R11 enable width and unmapped offsets
    wr(8'h2C, 32'hFFFF_FFFF);
    rdCheck("R11", 8'h2C, 32'h1);
    wr(8'h2C, 32'h0);
    rdCheck("R11 unmapped 0x24", 8'h24, 32'h0);
    rdCheck("R11 unmapped 0x00", 8'h00, 32'h0);
    rdCheck("R11 unmapped 0x3C", 8'h3C, 32'h0);

    // R9 weekly stub
    wr(8'h44, 32'h1);
    wr(8'h48, 32'h1);
    wr(8'h4C, 32'h1);
    rdCheck("R9 week en", 8'h44, 32'h1);
    rdCheck("R9 week irq en", 8'h48, 32'h1);
    rdCheck("R9 week pend", 8'h4C, 32'h0);
    check("R9 irq quiet", {31'b0, irq}, 32'h0);
    wr(8'h44, 32'h0);
    wr(8'h48, 32'h0);

    // R3 hold without run enable or without tick
    wr(8'h20, 32'd3);
    pulse(); pulse();
    rdCheck("R3 no run", 8'h20, 32'd3);
    wr(8'h28, 32'h1);
    repeat (5) @(negedge clk);
    rdCheck("R3 no tick", 8'h20, 32'd3);
    wr(8'h28, 32'h0);

    // R3 R5 R8 sweep over output enables and counts
    for (int m = 0; m < 4; m++) begin
      for (int n = 1; n <= 5; n++) begin
        wr(8'h28, 32'h0);
        wr(8'h30, 32'h1);
        wr(8'h2C, m & 1);
        wr(8'h50, (m >> 1) & 1);
        wr(8'h20, n);
        wr(8'h28, 32'h1);
        for (int k = 1; k <= n; k++) begin
          pulse();
          rdCheck("R3 sweep count", 8'h20, n - k);
          rdCheck("R5 sweep pending", 8'h30, (k == n) ? 1 : 0);
          check("R8 irq", {31'b0, irq}, ((k == n) && (m & 1)) ? 1 : 0);
          check("R8 wakeup", {31'b0, wakeup}, ((k == n) && ((m >> 1) & 1)) ? 1 : 0);
        end
      end
    end

    // R4 R5 extra ticks at zero, sticky pending
    pulse(); pulse();
    rdCheck("R4 stays zero", 8'h20, 32'h0);
    rdCheck("R5 sticky", 8'h30, 32'h1);

    // R6 clear semantics
    wr(8'h30, 32'h0);
    rdCheck("R6 write 0 no effect", 8'h30, 32'h1);
    wr(8'h30, 32'h1);
    rdCheck("R6 cleared", 8'h30, 32'h0);
    check("R6 irq low", {31'b0, irq}, 32'h0);
    check("R6 wakeup low", {31'b0, wakeup}, 32'h0);

    // R4 zero load never expires
    wr(8'h20, 32'h0);
    pulse(); pulse(); pulse();
    rdCheck("R4 zero count", 8'h20, 32'h0);
    rdCheck("R4 no pending", 8'h30, 32'h0);

    // R3 wide value
    wr(8'h20, 32'hFFFF_FFFF);
    pulse();
    rdCheck("R3 wide", 8'h20, 32'hFFFF_FFFE);

    // R7 expiry beats clear
    wr(8'h20, 32'h1);
    @(negedge clk);
    tick = 1'b1; wrEn = 1'b1; addr = 8'h30; wrData = 32'h1;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    rdCheck("R7 pending kept", 8'h30, 32'h1);
    wr(8'h30, 32'h1);
    rdCheck("R7 later clear", 8'h30, 32'h0);

    // R10 load beats tick
    wr(8'h20, 32'd5);
    @(negedge clk);
    tick = 1'b1; wrEn = 1'b1; addr = 8'h20; wrData = 32'd9;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    rdCheck("R10 load wins", 8'h20, 32'd9);
    pulse();
    rdCheck("R10 then decrement", 8'h20, 32'd8);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  logic [7:0] i_offs [8] = '{8'h20, 8'h28, 8'h2C, 8'h30, 8'h44, 8'h48, 8'h4C, 8'h50};

endmodule